// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Unit

This block holds the four status flags of an SPI peripheral: transmit buffer empty, receive buffer full, receive overflow and mode fault. It folds them with enable bits into two interrupt request lines. One line serves the transmitter. The other is shared by the receiver and the error conditions. An SPI shift engine drives its event inputs with one-cycle strobes. It also drives one level input that stays high while a mode-fault condition exists. The CPU reaches the unit over a small register bus with separate read and write strobes.

Each flag goes back to zero only through its own access sequence on the bus. A flag-setting event always wins over a clear that lands in the same cycle. The unit also gates the serial clock and the MISO driver from slave select when the port runs as a slave. A deselected slave drives nothing and ignores clock edges, even in the middle of a byte.

Top module: `spi_flag_irq_unit`

## Requirements
- R1: The receive-full flag (status bit 1) is set by `ev_rx_done`. It clears only on a data read (`bus_sel`=2) that follows a status read (`bus_sel`=0) made while the flag was 1. Any other access in between, such as a control read, disarms the clear.
- R2: The transmit-empty flag (status bit 0) is cleared by a data write alone, with no status read needed. `ev_tx_load` sets it.
- R3: The overflow flag (status bit 2) is set by `ev_ovf`. It clears on a data read that follows a status read made while it was 1. Any other access in between disarms the clear.
- R4: The mode-fault flag (status bit 3) is set while `modf_cond` is high. It clears on a control write (`bus_sel`=1) that follows a status read made while it was 1. The clear is refused if `modf_cond` was high at the status read or at any cycle up to the write.
- R5: `irq_tx` is 1 exactly when transmit-empty, the transmit interrupt enable (control bit 2) and the SPI enable (control bit 0) are all 1.
- R6: When the receive interrupt enable (control bit 3) is 1, `irq_rx_err` follows receive-full whatever the SPI enable.
- R7: When the error interrupt enable (status bit 4, writable) is 1, overflow and mode-fault each also drive `irq_rx_err`.
- R8: A mode fault never changes the SPI enable or any other control bit. Only a control write does.
- R9: When the port is a slave (control bit 1 = 0) and enabled, `slave_sel_n` = 1 forces `miso_oe` to 0 and `sck_gated` to 0 at once. This holds mid-transfer. When the port is selected, MISO carries `miso_in` and the clock passes. When disabled, both are 0. In master mode the clock passes and `miso_oe` is 0.
- R10: A set event in the same cycle as the access that would clear its flag leaves the flag set.
- R11: After reset, transmit-empty is 1, the other flags are 0 and every enable and control bit is 0.
- R12: The control register (`bus_sel`=1) reads back its four written bits [3:0]. A status read returns {err_ie, modf, ovf, rx_full, tx_empty} in bits [4:0]. A data read returns `rx_byte`. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 status, 1 control, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| rx_byte | input | 8 | Received byte from the shift engine |
| ev_rx_done | input | 1 | Byte received strobe |
| ev_tx_load | input | 1 | Transmit buffer moved to shifter strobe |
| ev_ovf | input | 1 | Overflow detected strobe |
| modf_cond | input | 1 | Mode-fault condition present (level) |
| slave_sel_n | input | 1 | Slave select, active low |
| sck_in | input | 1 | Serial clock from the pin |
| miso_in | input | 1 | Serial data from the shifter |
| sck_gated | output | 1 | Serial clock passed to the shifter |
| miso_out | output | 1 | MISO data |
| miso_oe | output | 1 | MISO output enable (0 = high impedance) |
| irq_tx | output | 1 | Transmitter interrupt request |
| irq_rx_err | output | 1 | Receiver/error interrupt request |

## Verification
A clearing access and the event that sets the same flag can land in the same clock. Likewise, a mode-fault condition can come back while its clear sequence is half done. The bench forces these collisions by driving the event strobe, or raising `modf_cond`, in the same negedge slot as the data read, data write or status read. It then watches the interrupt lines, which expose the flags without re-arming them. A flag that drops after any of these collisions is judged a failure.

// File: rtl/spi_flag_pkg.sv
// Package: register selects and bit positions shared by the flag unit.
package spi_flag_pkg;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_STAT = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    // status register bit positions
    localparam int ST_TXE  = 0;
    localparam int ST_RXF  = 1;
    localparam int ST_OVF  = 2;
    localparam int ST_MODF = 3;
    localparam int ST_EIE  = 4;

    // control register bit positions
    localparam int CT_SPE  = 0;
    localparam int CT_MSTR = 1;
    localparam int CT_TIE  = 2;
    localparam int CT_RIE  = 3;
    localparam int CT_BITS = 4;

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
        logic mstr;
        logic spe;
    } ctrl_t;
endpackage

// File: rtl/spi_ctrl_regs.sv
// Module: control and enable registers.
// Holds SPI enable, master select and the three interrupt enables.
// Assumes write strobes are already decoded, one per register.
// Only bus writes change these bits; no flag or fault touches them.
module spi_ctrl_regs
    import spi_flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic         wr_stat,
    input  logic [W-1:0] wdata,
    output ctrl_t        ctrl,
    output logic         err_ie
);
    // control register: written whole from the low bits
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(wdata[CT_BITS-1:0]);
    end

    // error enable lives in the status register
    always_ff @(posedge clk) begin
        if (!rst_n)       err_ie <= 1'b0;
        else if (wr_stat) err_ie <= wdata[ST_EIE];
    end

    AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl)); // R8
endmodule

// File: rtl/spi_flag_bank.sv
// Module: the four status flags and their armed clear sequences.
// A status read arms a clear for each flag that reads as 1. Any other
// access disarms all of them after taking its own effect. Set events
// take priority over clears. The mode-fault arm drops whenever the
// fault condition is high.
module spi_flag_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic data_rd,
    input  logic data_wr,
    input  logic ctrl_wr,
    input  logic other_acc,
    input  logic ev_rx_done,
    input  logic ev_tx_load,
    input  logic ev_ovf,
    input  logic modf_cond,
    output logic tx_empty,
    output logic rx_full,
    output logic ovf,
    output logic modf
);
    logic arm_rx, arm_ovf, arm_modf;

    // arming state of each two-step clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_rx   <= 1'b0;
            arm_ovf  <= 1'b0;
            arm_modf <= 1'b0;
        end else begin
            if (stat_rd) begin
                arm_rx  <= rx_full;
                arm_ovf <= ovf;
            end else if (other_acc) begin
                arm_rx  <= 1'b0;
                arm_ovf <= 1'b0;
            end
            if (modf_cond)      arm_modf <= 1'b0;
            else if (stat_rd)   arm_modf <= modf;
            else if (other_acc) arm_modf <= 1'b0;
        end
    end

    // flag updates, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_empty <= 1'b1;
            rx_full  <= 1'b0;
            ovf      <= 1'b0;
            modf     <= 1'b0;
        end else begin
            if (ev_tx_load)   tx_empty <= 1'b1;
            else if (data_wr) tx_empty <= 1'b0;

            if (ev_rx_done)             rx_full <= 1'b1;
            else if (arm_rx && data_rd) rx_full <= 1'b0;

            if (ev_ovf)                  ovf <= 1'b1;
            else if (arm_ovf && data_rd) ovf <= 1'b0;

            if (modf_cond)                modf <= 1'b1;
            else if (arm_modf && ctrl_wr) modf <= 1'b0;
        end
    end

    AST_RXF_FALL_NEEDS_DATA_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(data_rd)); // R1
    AST_TXE_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !ev_tx_load) |=> !tx_empty); // R2
    AST_OVF_FALL_NEEDS_DATA_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf) |-> $past(data_rd)); // R3
    AST_MODF_HELD_BY_COND: assert property (@(posedge clk) disable iff (!rst_n)
        modf_cond |=> modf); // R4
    AST_RX_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |=> rx_full); // R10
    AST_TX_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_load |=> tx_empty); // R10
endmodule

// File: rtl/spi_ss_gate.sv
// Module: slave-select gating of the serial clock and MISO driver.
// Purely combinational. Assumes slave_sel_n is already synchronised.
// A deselected slave drops the clock at once, mid-byte included.
module spi_ss_gate (
    input  logic spe,
    input  logic mstr,
    input  logic slave_sel_n,
    input  logic sck_in,
    input  logic miso_in,
    output logic sck_gated,
    output logic miso_out,
    output logic miso_oe
);
    logic slave_live;

    // gate decision for clock and data driver
    always_comb begin
        slave_live = spe && !mstr && !slave_sel_n;
        sck_gated  = (slave_live || (spe && mstr)) ? sck_in : 1'b0;
        miso_oe    = slave_live;
        miso_out   = slave_live ? miso_in : 1'b0;
    end

    always_comb begin
        AST_DESELECT_HIZ: assert (!(spe && !mstr && slave_sel_n) || (!miso_oe && !sck_gated)); // R9
    end
endmodule

// File: rtl/spi_flag_irq_unit.sv
// Module: top of the SPI status flag and interrupt unit.
// Decodes the register bus, instantiates the control registers, the flag
// bank and the slave-select gate. Forms the two interrupt requests.
// Assumes bus strobes last one cycle per access and read data is taken
// in the same cycle as the strobe.
module spi_flag_irq_unit
    import spi_flag_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [SW-1:0] bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] rx_byte,
    input  logic          ev_rx_done,
    input  logic          ev_tx_load,
    input  logic          ev_ovf,
    input  logic          modf_cond,
    input  logic          slave_sel_n,
    input  logic          sck_in,
    input  logic          miso_in,
    output logic          sck_gated,
    output logic          miso_out,
    output logic          miso_oe,
    output logic          irq_tx,
    output logic          irq_rx_err
);
    logic  stat_rd, stat_wr, ctrl_rd, ctrl_wr, data_rd, data_wr, other_acc;
    ctrl_t ctrl;
    logic  err_ie, tx_empty, rx_full, ovf, modf;

    // access decode
    always_comb begin
        stat_rd   = bus_rd && (bus_sel == SEL_STAT);
        stat_wr   = bus_wr && (bus_sel == SEL_STAT);
        ctrl_rd   = bus_rd && (bus_sel == SEL_CTRL);
        ctrl_wr   = bus_wr && (bus_sel == SEL_CTRL);
        data_rd   = bus_rd && (bus_sel == SEL_DATA);
        data_wr   = bus_wr && (bus_sel == SEL_DATA);
        other_acc = (bus_rd || bus_wr) && !stat_rd;
    end

    spi_ctrl_regs #(.W(DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (ctrl_wr),
        .wr_stat (stat_wr),
        .wdata   (bus_wdata),
        .ctrl    (ctrl),
        .err_ie  (err_ie)
    );

    spi_flag_bank u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_rd    (stat_rd),
        .data_rd    (data_rd),
        .data_wr    (data_wr),
        .ctrl_wr    (ctrl_wr),
        .other_acc  (other_acc),
        .ev_rx_done (ev_rx_done),
        .ev_tx_load (ev_tx_load),
        .ev_ovf     (ev_ovf),
        .modf_cond  (modf_cond),
        .tx_empty   (tx_empty),
        .rx_full    (rx_full),
        .ovf        (ovf),
        .modf       (modf)
    );

    spi_ss_gate u_gate (
        .spe         (ctrl.spe),
        .mstr        (ctrl.mstr),
        .slave_sel_n (slave_sel_n),
        .sck_in      (sck_in),
        .miso_in     (miso_in),
        .sck_gated   (sck_gated),
        .miso_out    (miso_out),
        .miso_oe     (miso_oe)
    );

    // read data mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_sel)
            SEL_STAT: begin
                bus_rdata[ST_TXE]  = tx_empty;
                bus_rdata[ST_RXF]  = rx_full;
                bus_rdata[ST_OVF]  = ovf;
                bus_rdata[ST_MODF] = modf;
                bus_rdata[ST_EIE]  = err_ie;
            end
            SEL_CTRL: bus_rdata[CT_BITS-1:0] = ctrl;
            SEL_DATA: bus_rdata = rx_byte;
            default:  bus_rdata = '0;
        endcase
    end

    // interrupt request forming
    always_comb begin
        irq_tx     = tx_empty && ctrl.tx_ie && ctrl.spe;
        irq_rx_err = (rx_full && ctrl.rx_ie) || (err_ie && (ovf || modf));
    end

    AST_TX_IRQ_NEEDS_SPE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> (ctrl.spe && tx_empty)); // R5
    AST_RX_IRQ_IGNORES_SPE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && ctrl.rx_ie) |-> irq_rx_err); // R6
    AST_ERR_IRQ_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ie && (ovf || modf)) |-> irq_rx_err); // R7
endmodule

// File: tb/tb_spi_flag_irq_unit.sv
`timescale 1ns/1ps
module tb_spi_flag_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 0, bus_wr = 0;
    logic [1:0] bus_sel = 0;
    logic [7:0] bus_wdata = 0, rx_byte = 8'hA5;
    logic [7:0] bus_rdata;
    logic       ev_rx_done = 0, ev_tx_load = 0, ev_ovf = 0, modf_cond = 0;
    logic       slave_sel_n = 1, sck_in = 0, miso_in = 0;
    logic       sck_gated, miso_out, miso_oe, irq_tx, irq_rx_err;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    spi_flag_irq_unit dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic bus_op(input logic rd, input logic wr, input logic [1:0] sel,
                          input logic [7:0] wd, output logic [7:0] rdv);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_sel = sel; bus_wdata = wd;
        #1 rdv = bus_rdata;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
    endtask

    // which: 0 rx_done, 1 tx_load, 2 ovf
    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) ev_rx_done = 1;
        if (which == 1) ev_tx_load = 1;
        if (which == 2) ev_ovf = 1;
        @(negedge clk);
        ev_rx_done = 0; ev_tx_load = 0; ev_ovf = 0;
    endtask

    initial begin
        logic [7:0] d;
        do_reset();
        // R11 reset state
        bus_op(1, 0, 2'd0, 0, rv); chk("R11 status", rv, 8'h01);
        bus_op(1, 0, 2'd1, 0, rv); chk("R11 ctrl", rv, 8'h00);
        chk("R11 irqs", {6'b0, irq_tx, irq_rx_err}, 8'h00);
        // R12 readback
        bus_op(0, 1, 2'd1, 8'hFF, d); bus_op(1, 0, 2'd1, 0, rv); chk("R12 ctrl", rv, 8'h0F);
        bus_op(0, 1, 2'd0, 8'hFF, d); bus_op(1, 0, 2'd0, 0, rv); chk("R12 status", rv, 8'h11);
        bus_op(1, 0, 2'd2, 0, rv); chk("R12 data", rv, 8'hA5);

        // R5 R6 R7 sweep of enables and flag states
        for (int v = 0; v < 128; v++) begin
            logic spe, tie, rie, eie, txclr, rxf, ov;
            {ov, rxf, txclr, eie, rie, tie, spe} = v[6:0];
            do_reset();
            bus_op(0, 1, 2'd1, {4'b0, rie, tie, 1'b0, spe}, d);
            bus_op(0, 1, 2'd0, {3'b0, eie, 4'b0}, d);
            if (txclr) bus_op(0, 1, 2'd2, 8'h00, d);
            if (rxf) pulse(0);
            if (ov) pulse(2);
            chk("R5 irq_tx sweep", {7'b0, irq_tx}, {7'b0, !txclr && tie && spe});
            chk("R6 R7 irq_rx_err sweep", {7'b0, irq_rx_err}, {7'b0, (rxf && rie) || (eie && ov)});
        end

        // R1 receive-full clear sequence, observed on irq_rx_err
        do_reset();
        bus_op(0, 1, 2'd1, 8'h08, d);
        pulse(0);
        bus_op(1, 0, 2'd2, 0, d);
        chk("R1 data read alone keeps flag", {7'b0, irq_rx_err}, 8'h01);
        bus_op(1, 0, 2'd0, 0, d); bus_op(1, 0, 2'd1, 0, d); bus_op(1, 0, 2'd2, 0, d);
        chk("R1 other access disarms", {7'b0, irq_rx_err}, 8'h01);
        bus_op(1, 0, 2'd0, 0, d); bus_op(1, 0, 2'd2, 0, d);
        chk("R1 status then data clears", {7'b0, irq_rx_err}, 8'h00);

        // R10 set wins over clearing data read
        pulse(0);
        bus_op(1, 0, 2'd0, 0, d);
        @(negedge clk); bus_rd = 1; bus_sel = 2'd2; ev_rx_done = 1;
        @(negedge clk); bus_rd = 0; ev_rx_done = 0;
        chk("R10 rx event beats clear", {7'b0, irq_rx_err}, 8'h01);

        // R2 and R10 transmit-empty
        do_reset();
        bus_op(0, 1, 2'd1, 8'h05, d);
        chk("R2 tx irq after enable", {7'b0, irq_tx}, 8'h01);
        bus_op(0, 1, 2'd2, 8'h3C, d);
        chk("R2 data write clears", {7'b0, irq_tx}, 8'h00);
        pulse(1);
        chk("R2 tx load sets", {7'b0, irq_tx}, 8'h01);
        @(negedge clk); bus_wr = 1; bus_sel = 2'd2; ev_tx_load = 1;
        @(negedge clk); bus_wr = 0; ev_tx_load = 0;
        chk("R10 tx event beats write", {7'b0, irq_tx}, 8'h01);

        // R3 overflow clear sequence
        do_reset();
        bus_op(0, 1, 2'd0, 8'h10, d);
        pulse(2);
        bus_op(1, 0, 2'd2, 0, d);
        chk("R3 data read alone keeps ovf", {7'b0, irq_rx_err}, 8'h01);
        bus_op(1, 0, 2'd0, 0, d); bus_op(0, 1, 2'd1, 8'h00, d); bus_op(1, 0, 2'd2, 0, d);
        chk("R3 write between disarms", {7'b0, irq_rx_err}, 8'h01);
        bus_op(1, 0, 2'd0, 0, d); bus_op(1, 0, 2'd2, 0, d);
        chk("R3 status then data clears", {7'b0, irq_rx_err}, 8'h00);

        // R4 and R8 mode fault
        do_reset();
        bus_op(0, 1, 2'd1, 8'h01, d);
        bus_op(0, 1, 2'd0, 8'h10, d);
        @(negedge clk); modf_cond = 1; @(negedge clk); modf_cond = 0;
        chk("R4 modf sets", {7'b0, irq_rx_err}, 8'h01);
        bus_op(1, 0, 2'd1, 0, rv); chk("R8 spe kept after fault", rv, 8'h01);
        @(negedge clk); modf_cond = 1;
        bus_op(1, 0, 2'd0, 0, d);
        @(negedge clk); modf_cond = 0;
        bus_op(0, 1, 2'd1, 8'h01, d);
        chk("R4 clear refused during fault", {7'b0, irq_rx_err}, 8'h01);
        bus_op(1, 0, 2'd0, 0, d);
        @(negedge clk); modf_cond = 1; @(negedge clk); modf_cond = 0;
        bus_op(0, 1, 2'd1, 8'h01, d);
        chk("R4 clear refused after mid-sequence fault", {7'b0, irq_rx_err}, 8'h01);
        bus_op(1, 0, 2'd0, 0, d); bus_op(0, 1, 2'd1, 8'h01, d);
        chk("R4 clean sequence clears", {7'b0, irq_rx_err}, 8'h00);
        bus_op(0, 1, 2'd1, 8'h00, d); bus_op(1, 0, 2'd1, 0, rv);
        chk("R8 software clears spe", rv, 8'h00);

        // R9 slave-select gating sweep
        for (int g = 0; g < 16; g++) begin
            logic spe, ms, ssn, ck, live;
            {ck, ssn, ms, spe} = g[3:0];
            bus_op(0, 1, 2'd1, {6'b0, ms, spe}, d);
            @(negedge clk); slave_sel_n = ssn; sck_in = ck; miso_in = 1;
            #1;
            live = spe && !ms && !ssn;
            chk("R9 miso_oe", {7'b0, miso_oe}, {7'b0, live});
            chk("R9 miso_out", {7'b0, miso_out}, {7'b0, live});
            chk("R9 sck_gated", {7'b0, sck_gated}, {7'b0, (live || (spe && ms)) && ck});
        end
        // R9 deselect mid-transfer
        bus_op(0, 1, 2'd1, 8'h01, d);
        @(negedge clk); slave_sel_n = 0; sck_in = 1; #1;
        chk("R9 selected clock passes", {7'b0, sck_gated}, 8'h01);
        slave_sel_n = 1; #1;
        chk("R9 mid-byte deselect blocks clock", {6'b0, sck_gated, miso_oe}, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule